// File: doc/BRIEF.md
# Huge-Page Translation Cache

This block is a small fully associative store of finished virtual-to-physical translations placed ahead of a page table walker. A lookup presents a 48-bit virtual address together with the access kind (write, user mode, instruction fetch). In the same cycle, with no register on the path, the block answers hit or miss, the 52-bit physical address and the permissions held for the matching entry, and raises a fault flag when the access breaks those permissions. A miss tells the walker to run. When the walker finishes, it writes its result through the fill port. The result carries the frame base, the mapping size (4 KB, 2 MB or 1 GB), the combined write, user and no-execute permissions, and a global flag.

Each slot covers its whole mapping. A 1 GB page therefore uses one slot, and only the virtual bits above the page offset take part in the tag compare. The physical address is built from the upper frame base bits of the slot and the untranslated low virtual bits. A write to the root table base register clears every slot that is not global. A separate flush-all input clears every slot and returns the replacement state to its reset value.

Top module: `hp_tlb`

## Requirements
- R1: After reset no lookup hits. While `lk_req_i` is 1, exactly one of `lk_hit_o` and `lk_miss_o` is 1 in the same cycle. While `lk_req_i` is 0, both are 0.
- R2: A 4 KB entry (`fill_size_i` = 0) matches when virtual bits 47:12 are equal to those of the fill address. The physical address is then the 40-bit frame base followed by virtual bits 11:0. A lookup in the neighbouring 4 KB page misses.
- R3: A 2 MB entry (`fill_size_i` = 1) matches on virtual bits 47:21 only. The physical address is frame base bits 39:9 followed by virtual bits 20:0. The value 3 on `fill_size_i` is treated as 4 KB.
- R4: A 1 GB entry (`fill_size_i` = 2) matches on virtual bits 47:30, so one slot answers for any offset in the whole 1 GB range. The physical address is frame base bits 39:18 followed by virtual bits 29:0.
- R5: A pulse on `root_wr_i` clears, at that clock edge, every slot whose global flag is 0 and keeps the global slots. A fill in the same cycle is still installed, even when it is not global.
- R6: A pulse on `flush_all_i` clears every slot, global ones included, and sets the round-robin pointer back to slot 0.
- R7: When several valid slots match a lookup, the slot with the lowest index supplies the result, whatever the page sizes.
- R8: A fill goes into the lowest-index empty slot. When all slots are valid, it replaces the slot under a round-robin pointer, which starts at 0 after reset or flush-all and moves forward by one only on such replacements.
- R9: On a hit, `lk_fault_o` is 1 exactly when the access is a write to a slot that is not writable, a user access to a slot that is not a user slot, or a fetch from a no-execute slot. On a miss it is 0.
- R10: On a hit, `lk_perm_o` shows the cached permissions as bit 2 no-execute, bit 1 user, bit 0 write. A fill becomes visible to lookups in the cycle after its clock edge.
- R11: A fill in the same cycle as `flush_all_i` is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_req_i | input | 1 | Lookup valid |
| lk_va_i | input | 48 | Lookup virtual address |
| lk_write_i | input | 1 | Lookup is a write |
| lk_user_i | input | 1 | Lookup comes from user mode |
| lk_exec_i | input | 1 | Lookup is an instruction fetch |
| lk_hit_o | output | 1 | Translation found |
| lk_miss_o | output | 1 | No translation; the walker must run |
| lk_pa_o | output | 52 | Translated physical address |
| lk_perm_o | output | 3 | Cached permissions {no-execute, user, write} |
| lk_fault_o | output | 1 | Hit that violates the cached permissions |
| fill_i | input | 1 | Install the walker result |
| fill_va_i | input | 48 | Virtual address that was walked |
| fill_pfn_i | input | 40 | Frame base, physical bits 51:12 |
| fill_size_i | input | 2 | 0 = 4 KB, 1 = 2 MB, 2 = 1 GB, 3 = 4 KB |
| fill_write_i | input | 1 | Mapping is writable |
| fill_user_i | input | 1 | Mapping is user accessible |
| fill_nx_i | input | 1 | Mapping is no-execute |
| fill_global_i | input | 1 | Mapping survives a root register write |
| root_wr_i | input | 1 | Root table base register written |
| flush_all_i | input | 1 | Clear every slot and the replacement pointer |

## Verification
Two situations are hard to reach from the ports. One is round-robin replacement, which happens only once all sixteen slots are valid. The other is overlap priority, which needs a small page and a covering huge page to be resident together. Directed sequences fill the array to capacity from a flushed start and then watch which old page disappears. They also install a 4 KB page and the 2 MB page that covers it, in both orders. Random traffic draws its addresses from a small pool of bases and varies the low bits at random. This makes fills of mixed sizes overlap often, and mixes root writes and global fills in, so that full-array replacement and partial clearing happen again and again.

// File: rtl/hp_tlb_pkg.sv
`timescale 1ns/1ps
package hp_tlb_pkg;
  parameter int unsigned VA_W  = 48;
  parameter int unsigned PA_W  = 52;
  parameter int unsigned OFF_W = 12;
  parameter int unsigned LVL_W = 9;
  localparam int unsigned VPN_W = VA_W - OFF_W;
  localparam int unsigned PFN_W = PA_W - OFF_W;

  typedef enum logic [1:0] {
    PG_4K = 2'd0,
    PG_2M = 2'd1,
    PG_1G = 2'd2
  } pg_size_e;

  typedef struct packed {
    logic nx;
    logic user;
    logic wr;
  } perm_t;

  typedef struct packed {
    logic [VPN_W-1:0] vpn;
    logic [PFN_W-1:0] pfn;
    pg_size_e         size;
    perm_t            perm;
    logic             glob;
  } tlb_entry_t;

  // Ones on the page number bits that take part in the compare
  function automatic logic [VPN_W-1:0] vpn_keep(pg_size_e s);
    logic [VPN_W-1:0] m;
    m = '1;
    case (s)
      PG_2M:   m[LVL_W-1:0]   = '0;
      PG_1G:   m[2*LVL_W-1:0] = '0;
      default: ;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/hp_tlb_entry.sv
`timescale 1ns/1ps
module hp_tlb_entry
  import hp_tlb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_all_i,
  input  logic             clr_local_i,
  input  logic             wr_en_i,
  input  tlb_entry_t       wr_data_i,
  input  logic [VA_W-1:0]  lk_va_i,
  output logic             valid_o,
  output logic             glob_o,
  output logic             match_o,
  output logic [PA_W-1:0]  pa_o,
  output perm_t            perm_o
);
  localparam int unsigned EXT_W = PFN_W - VPN_W;  // needs PA_W > VA_W

  tlb_entry_t       ent_q;
  logic             valid_q;
  logic [VPN_W-1:0] keep;
  logic [PA_W-1:0]  pa_keep;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      ent_q   <= '0;
    end else if (clr_all_i) begin
      valid_q <= 1'b0;
    end else if (wr_en_i) begin
      valid_q <= 1'b1;
      ent_q   <= wr_data_i;
    end else if (clr_local_i && !ent_q.glob) begin
      valid_q <= 1'b0;
    end
  end

  always_comb begin
    keep    = vpn_keep(ent_q.size);
    match_o = valid_q && (((lk_va_i[VA_W-1:OFF_W] ^ ent_q.vpn) & keep) == '0);
    // frame bits above the page size, virtual bits below it
    pa_keep = {{EXT_W{1'b1}}, keep, {OFF_W{1'b0}}};
    pa_o    = ({ent_q.pfn, {OFF_W{1'b0}}} & pa_keep) | (PA_W'(lk_va_i) & ~pa_keep);
  end

  assign valid_o = valid_q;
  assign glob_o  = ent_q.glob;
  assign perm_o  = ent_q.perm;
endmodule

// File: rtl/hp_tlb_victim.sv
`timescale 1ns/1ps
module hp_tlb_victim #(
  parameter int unsigned N     = 16,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             alloc_i,
  input  logic [N-1:0]     valid_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [IDX_W-1:0] ptr_o
);
  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] free_idx;
  logic             free;

  always_comb begin
    free     = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        free     = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
    idx_o = free ? free_idx : ptr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (flush_i) begin
      ptr_q <= '0;
    end else if (alloc_i && !free) begin
      ptr_q <= (ptr_q == IDX_W'(N - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/hp_tlb_sel.sv
`timescale 1ns/1ps
module hp_tlb_sel
  import hp_tlb_pkg::*;
#(
  parameter int unsigned N = 16
) (
  input  logic [N-1:0]           match_i,
  input  logic [N-1:0][PA_W-1:0] pa_i,
  input  perm_t [N-1:0]          perm_i,
  output logic                   hit_o,
  output logic [PA_W-1:0]        pa_o,
  output perm_t                  perm_o,
  output logic [N-1:0]           sel_oh_o
);
  always_comb begin
    sel_oh_o = '0;
    hit_o    = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (match_i[i] && !hit_o) begin
        sel_oh_o[i] = 1'b1;
        hit_o       = 1'b1;
      end
    end
  end

  always_comb begin
    pa_o   = '0;
    perm_o = '0;
    for (int i = 0; i < N; i++) begin
      pa_o   = pa_o | (pa_i[i] & {PA_W{sel_oh_o[i]}});
      perm_o = perm_t'(perm_o | (perm_i[i] & {3{sel_oh_o[i]}}));
    end
  end
endmodule

// File: rtl/hp_tlb.sv
`timescale 1ns/1ps
module hp_tlb
  import hp_tlb_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_req_i,
  input  logic [VA_W-1:0]   lk_va_i,
  input  logic              lk_write_i,
  input  logic              lk_user_i,
  input  logic              lk_exec_i,
  output logic              lk_hit_o,
  output logic              lk_miss_o,
  output logic [PA_W-1:0]   lk_pa_o,
  output logic [2:0]        lk_perm_o,
  output logic              lk_fault_o,
  input  logic              fill_i,
  input  logic [VA_W-1:0]   fill_va_i,
  input  logic [PFN_W-1:0]  fill_pfn_i,
  input  logic [1:0]        fill_size_i,
  input  logic              fill_write_i,
  input  logic              fill_user_i,
  input  logic              fill_nx_i,
  input  logic              fill_global_i,
  input  logic              root_wr_i,
  input  logic              flush_all_i
);
  localparam int unsigned N     = NUM_ENTRIES;
  localparam int unsigned IDX_W = $clog2(N);

  logic [N-1:0]           ent_valid;
  logic [N-1:0]           ent_glob;
  logic [N-1:0]           ent_match;
  logic [N-1:0][PA_W-1:0] ent_pa;
  perm_t [N-1:0]          ent_perm;
  logic [N-1:0]           sel_oh;
  logic [IDX_W-1:0]       victim;
  logic [IDX_W-1:0]       rr_ptr;
  logic                   wr_en;
  tlb_entry_t             fill_ent;
  logic                   any_hit;
  logic [PA_W-1:0]        hit_pa;
  perm_t                  hit_perm;

  assign wr_en = fill_i && !flush_all_i;

  always_comb begin
    fill_ent.vpn       = fill_va_i[VA_W-1:OFF_W];
    fill_ent.pfn       = fill_pfn_i;
    fill_ent.size      = (fill_size_i == 2'd3) ? PG_4K : pg_size_e'(fill_size_i);
    fill_ent.perm.nx   = fill_nx_i;
    fill_ent.perm.user = fill_user_i;
    fill_ent.perm.wr   = fill_write_i;
    fill_ent.glob      = fill_global_i;
  end

  hp_tlb_victim #(.N(N), .IDX_W(IDX_W)) u_victim (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush_all_i),
    .alloc_i (wr_en),
    .valid_i (ent_valid),
    .idx_o   (victim),
    .ptr_o   (rr_ptr)
  );

  for (genvar g = 0; g < N; g++) begin : g_ent
    hp_tlb_entry u_ent (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .clr_all_i   (flush_all_i),
      .clr_local_i (root_wr_i),
      .wr_en_i     (wr_en && (victim == IDX_W'(g))),
      .wr_data_i   (fill_ent),
      .lk_va_i     (lk_va_i),
      .valid_o     (ent_valid[g]),
      .glob_o      (ent_glob[g]),
      .match_o     (ent_match[g]),
      .pa_o        (ent_pa[g]),
      .perm_o      (ent_perm[g])
    );
  end

  hp_tlb_sel #(.N(N)) u_sel (
    .match_i  (ent_match),
    .pa_i     (ent_pa),
    .perm_i   (ent_perm),
    .hit_o    (any_hit),
    .pa_o     (hit_pa),
    .perm_o   (hit_perm),
    .sel_oh_o (sel_oh)
  );

  assign lk_hit_o   = lk_req_i && any_hit;
  assign lk_miss_o  = lk_req_i && !any_hit;
  assign lk_pa_o    = hit_pa;
  assign lk_perm_o  = hit_perm;
  assign lk_fault_o = lk_hit_o && ((lk_write_i && !hit_perm.wr) ||
                                   (lk_user_i  && !hit_perm.user) ||
                                   (lk_exec_i  &&  hit_perm.nx));
endmodule

// File: rtl/hp_tlb_chk.sv
`timescale 1ns/1ps
module hp_tlb_chk
  import hp_tlb_pkg::*;
#(
  parameter int unsigned N     = 16,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             lk_req_i,
  input logic [VA_W-1:0]  lk_va_i,
  input logic             lk_hit_o,
  input logic             lk_miss_o,
  input logic [PA_W-1:0]  lk_pa_o,
  input logic             lk_fault_o,
  input logic             fill_i,
  input logic             root_wr_i,
  input logic             flush_all_i,
  input logic [N-1:0]     ent_valid,
  input logic [N-1:0]     ent_glob,
  input logic [N-1:0]     sel_oh,
  input logic [IDX_W-1:0] rr_ptr
);
  logic [IDX_W-1:0] rr_step;
  assign rr_step = (rr_ptr == IDX_W'(N - 1)) ? '0 : rr_ptr + 1'b1;

  assert_req_answer_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_req_i |-> (lk_hit_o ^ lk_miss_o));
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_req_i |-> (!lk_hit_o && !lk_miss_o));
  assert_offset_kept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> (lk_pa_o[OFF_W-1:0] == lk_va_i[OFF_W-1:0]));
  assert_root_keeps_global_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (root_wr_i && !flush_all_i && !fill_i) |=> (ent_valid == $past(ent_valid & ent_glob)));
  assert_flush_empties_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_all_i |=> (ent_valid == '0 && rr_ptr == '0));
  assert_single_winner_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_oh));
  assert_rr_advance_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && !flush_all_i && (&ent_valid)) |=> (rr_ptr == $past(rr_step)));
  assert_fault_on_hit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_fault_o |-> lk_hit_o);
endmodule

bind hp_tlb hp_tlb_chk #(.N(NUM_ENTRIES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .lk_req_i    (lk_req_i),
  .lk_va_i     (lk_va_i),
  .lk_hit_o    (lk_hit_o),
  .lk_miss_o   (lk_miss_o),
  .lk_pa_o     (lk_pa_o),
  .lk_fault_o  (lk_fault_o),
  .fill_i      (fill_i),
  .root_wr_i   (root_wr_i),
  .flush_all_i (flush_all_i),
  .ent_valid   (ent_valid),
  .ent_glob    (ent_glob),
  .sel_oh      (sel_oh),
  .rr_ptr      (rr_ptr)
);

// File: tb/hp_tlb_bench.sv
`timescale 1ns/1ps
module hp_tlb_bench;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_req = 1'b0, lk_w = 1'b0, lk_u = 1'b0, lk_x = 1'b0;
  logic [47:0] lk_va = '0;
  logic        hit, miss, fault;
  logic [51:0] pa;
  logic [2:0]  perm;
  logic        f_en = 1'b0, f_w = 1'b0, f_u = 1'b0, f_nx = 1'b0, f_g = 1'b0;
  logic [47:0] f_va = '0;
  logic [39:0] f_pfn = '0;
  logic [1:0]  f_sz = '0;
  logic        root_wr = 1'b0, flush = 1'b0;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hp_tlb u_hp_tlb (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_req_i(lk_req), .lk_va_i(lk_va), .lk_write_i(lk_w), .lk_user_i(lk_u), .lk_exec_i(lk_x),
    .lk_hit_o(hit), .lk_miss_o(miss), .lk_pa_o(pa), .lk_perm_o(perm), .lk_fault_o(fault),
    .fill_i(f_en), .fill_va_i(f_va), .fill_pfn_i(f_pfn), .fill_size_i(f_sz),
    .fill_write_i(f_w), .fill_user_i(f_u), .fill_nx_i(f_nx), .fill_global_i(f_g),
    .root_wr_i(root_wr), .flush_all_i(flush)
  );

  // reference state
  bit          m_v[N];
  logic [35:0] m_vpn[N];
  logic [1:0]  m_sz[N];
  logic [39:0] m_pfn[N];
  logic [2:0]  m_pm[N];
  bit          m_g[N];
  int          m_ptr;

  task automatic model_lookup(input logic [47:0] va, output bit h,
                              output logic [51:0] epa, output logic [2:0] epm);
    h = 1'b0; epa = '0; epm = '0;
    for (int i = 0; i < N; i++) begin
      bit eq;
      if (!h && m_v[i]) begin
        case (m_sz[i])
          2'd1:    eq = (va[47:21] == m_vpn[i][35:9]);
          2'd2:    eq = (va[47:30] == m_vpn[i][35:18]);
          default: eq = (va[47:12] == m_vpn[i]);
        endcase
        if (eq) begin
          h = 1'b1;
          epm = m_pm[i];
          case (m_sz[i])
            2'd1:    epa = {m_pfn[i][39:9], va[20:0]};
            2'd2:    epa = {m_pfn[i][39:18], va[29:0]};
            default: epa = {m_pfn[i], va[11:0]};
          endcase
        end
      end
    end
  endtask

  task automatic model_apply(input bit fe, input logic [47:0] fva, input logic [39:0] fpfn,
                             input logic [1:0] fsz, input logic [2:0] fpm, input bit fg,
                             input bit rw, input bit fl);
    int vic;
    if (fl) begin
      for (int i = 0; i < N; i++) m_v[i] = 1'b0;
      m_ptr = 0;
      return;
    end
    vic = -1;
    if (fe) begin
      for (int i = N - 1; i >= 0; i--) if (!m_v[i]) vic = i;
      if (vic < 0) begin
        vic = m_ptr;
        m_ptr = (m_ptr + 1) % N;
      end
    end
    if (rw) for (int i = 0; i < N; i++) if (i != vic && !m_g[i]) m_v[i] = 1'b0;
    if (fe) begin
      m_v[vic] = 1'b1; m_vpn[vic] = fva[47:12]; m_sz[vic] = (fsz == 2'd3) ? 2'd0 : fsz;
      m_pfn[vic] = fpfn; m_pm[vic] = fpm; m_g[vic] = fg;
    end
  endtask

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare mid-low, update the model at the edge
  task automatic step(input string tag, input bit lq, input logic [47:0] va, input bit w, input bit u,
                      input bit x, input bit fe, input logic [47:0] fva, input logic [39:0] fpfn,
                      input logic [1:0] fsz, input logic [2:0] fpm, input bit fg,
                      input bit rw, input bit fl);
    bit eh;
    logic [51:0] epa;
    logic [2:0] epm;
    bit ef;
    @(negedge clk);
    lk_req = lq; lk_va = va; lk_w = w; lk_u = u; lk_x = x;
    f_en = fe; f_va = fva; f_pfn = fpfn; f_sz = fsz; f_nx = fpm[2]; f_u = fpm[1]; f_w = fpm[0]; f_g = fg;
    root_wr = rw; flush = fl;
    #5;
    model_lookup(va, eh, epa, epm);
    if (lq) begin
      chk(tag, "hit", 64'(hit), 64'(eh));
      chk(tag, "miss", 64'(miss), 64'(!eh));
      ef = eh && ((w && !epm[0]) || (u && !epm[1]) || (x && epm[2]));
      chk(tag, "fault", 64'(fault), 64'(ef));
      if (eh) begin
        chk(tag, "pa", 64'(pa), 64'(epa));
        chk(tag, "perm", 64'(perm), 64'(epm));
      end
    end else begin
      chk(tag, "idle", 64'({hit, miss}), 64'(0));
    end
    @(posedge clk);
    model_apply(fe, fva, fpfn, fsz, fpm, fg, rw, fl);
  endtask

  task automatic look(input string tag, input logic [47:0] va, input logic [2:0] acc);
    step(tag, 1'b1, va, acc[0], acc[1], acc[2], 1'b0, '0, '0, '0, '0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic fill(input string tag, input logic [47:0] va, input logic [39:0] pfn,
                      input logic [1:0] sz, input logic [2:0] pm, input bit g);
    step(tag, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1, va, pfn, sz, pm, g, 1'b0, 1'b0);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [47:0] pool[12];
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_g[i] = 0; end
    m_ptr = 0;
    void'($urandom(32'h5eed_2024));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: empty after reset, idle port quiet
    look("R1", 48'h0000_1234_5678, 3'b000);
    look("R1", 48'hFFFF_8000_0000, 3'b000);
    step("R1", 1'b0, 48'h0, 0, 0, 0, 0, '0, '0, '0, '0, 0, 0, 0);

    // R2: 4 KB page
    fill("R2", 48'h0000_1234_5000, 40'hAB_CDEF_0123, 2'd0, 3'b011, 1'b0);
    look("R2", 48'h0000_1234_5ABC, 3'b000);
    look("R2", 48'h0000_1234_6ABC, 3'b000);
    look("R2", 48'h0000_1234_4FFF, 3'b000);

    // R3: 2 MB page, both ends and the neighbour; size code 3 acts as 4 KB
    fill("R3", 48'h0000_7760_0000, 40'h12_3456_789A, 2'd1, 3'b001, 1'b0);
    look("R3", 48'h0000_7760_0000, 3'b000);
    look("R3", 48'h0000_777F_FFFF, 3'b000);
    look("R3", 48'h0000_7780_0000, 3'b000);
    fill("R3", 48'h0000_0AA0_0000, 40'h00_0000_0777, 2'd3, 3'b000, 1'b0);
    look("R3", 48'h0000_0AA0_0123, 3'b000);
    look("R3", 48'h0000_0AA0_1123, 3'b000);

    // R4: 1 GB page in one slot
    fill("R4", 48'h0012_4000_0000, 40'hFF_FFC0_1234, 2'd2, 3'b111, 1'b0);
    look("R4", 48'h0012_4000_0000, 3'b000);
    look("R4", 48'h0012_7FFF_FFFF, 3'b000);
    look("R4", 48'h0012_5A5A_5A5A, 3'b000);
    look("R4", 48'h0012_8000_0000, 3'b000);

    // R9 R10: permission faults
    look("R9", 48'h0000_7770_0010, 3'b001);
    look("R9", 48'h0000_7770_0010, 3'b010);
    look("R9", 48'h0012_4000_0010, 3'b100);
    look("R10", 48'h0000_1234_5010, 3'b011);
    look("R9", 48'h0000_0AA0_0000, 3'b111);

    // R7: overlap, lowest index wins regardless of size
    step("R6", 1'b0, '0, 0, 0, 0, 0, '0, '0, '0, '0, 0, 0, 1'b1);
    fill("R7", 48'h0000_4020_3000, 40'h00_0000_AAAA, 2'd0, 3'b011, 1'b0);
    fill("R7", 48'h0000_4020_0000, 40'h00_0BBB_B000, 2'd1, 3'b001, 1'b0);
    look("R7", 48'h0000_4020_3ABC, 3'b000);
    look("R7", 48'h0000_4031_0000, 3'b000);
    fill("R7", 48'h0000_9000_0000, 40'h00_0CCC_C000, 2'd1, 3'b001, 1'b0);
    fill("R7", 48'h0000_9000_5000, 40'h00_0000_DDDD, 2'd0, 3'b011, 1'b0);
    look("R7", 48'h0000_9000_5123, 3'b000);

    // R5: root write keeps global, same-cycle fill survives
    fill("R5", 48'hFFFF_8000_0000, 40'h00_0000_1000, 2'd2, 3'b001, 1'b1);
    step("R5", 1'b0, '0, 0, 0, 0, 1'b1, 48'h0000_5555_5000, 40'h00_0000_5555, 2'd0, 3'b011, 1'b0, 1'b1, 1'b0);
    look("R5", 48'hFFFF_8123_4567, 3'b000);
    look("R5", 48'h0000_5555_5777, 3'b000);
    look("R5", 48'h0000_4020_3ABC, 3'b000);
    look("R5", 48'h0000_9000_5123, 3'b000);

    // R11: fill dropped when flushing; R6: global cleared too
    step("R11", 1'b0, '0, 0, 0, 0, 1'b1, 48'h0000_6666_6000, 40'h00_0000_6666, 2'd0, 3'b011, 1'b1, 1'b0, 1'b1);
    look("R11", 48'h0000_6666_6000, 3'b000);
    look("R6", 48'hFFFF_8123_4567, 3'b000);

    // R8: fill to capacity then round-robin from slot 0
    for (int i = 0; i < N; i++)
      fill("R8", {24'h000100, 12'(i), 12'h000}, 40'(32'h7000 + i), 2'd0, 3'b011, 1'b0);
    for (int i = 0; i < 3; i++)
      fill("R8", {24'h000200, 12'(i), 12'h000}, 40'(32'h8000 + i), 2'd0, 3'b011, 1'b0);
    for (int i = 0; i < 5; i++) look("R8", {24'h000100, 12'(i), 12'h345}, 3'b000);
    look("R8", 48'h0002_0000_2345, 3'b000);
    step("R8", 1'b0, '0, 0, 0, 0, 0, '0, '0, '0, '0, 0, 1'b1, 1'b0);
    fill("R8", 48'h0000_3000_0000, 40'h00_0000_9999, 2'd0, 3'b011, 1'b0);
    look("R8", 48'h0000_3000_0001, 3'b000);

    // random mix against the reference
    for (int i = 0; i < 12; i++) pool[i] = {$urandom(), $urandom()} & 48'hFFFF_FFFF_FFFF;
    for (int n = 0; n < 4000; n++) begin
      int k, r;
      logic [47:0] va, lowm;
      r = $urandom_range(0, 99);
      k = $urandom_range(0, 11);
      case ($urandom_range(0, 2))
        0: lowm = 48'h0000_0000_0FFF;
        1: lowm = 48'h0000_001F_FFFF;
        default: lowm = 48'h0000_3FFF_FFFF;
      endcase
      va = (pool[k] & ~lowm) | (48'({$urandom(), $urandom()}) & lowm);
      if (r < 55)
        look("R10", va, 3'($urandom_range(0, 7)));
      else
        step("R8", 1'($urandom_range(0, 1)), va, 1'($urandom), 1'($urandom), 1'($urandom),
             r < 92, pool[$urandom_range(0, 11)], 40'({$urandom(), $urandom()}),
             2'($urandom_range(0, 3)), 3'($urandom_range(0, 7)), $urandom_range(0, 3) == 0,
             r >= 88 && r < 96, r >= 98);
    end

    finish_run();
  end
endmodule